// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Tracker

This block holds the replacement state of a 4-way set-associative cache. Each set keeps three bits that form a small binary tree over the ways. A root bit chooses one pair of ways, and two leaf bits each choose one way inside their pair. The bits record only a partial order of recent use, not a full recency ranking of the four ways. Only the tree direction that leads to the most recently touched way is changed.

The cache controller reports each access on the access port: a strobe, the set index and the way that was used. The bits of that set are rewritten on the next clock edge. When the controller needs a way to replace in a set, it puts the set index on the query port. The victim way that the bits of that set point to comes back combinationally. Tags, hit detection, data storage and any preference for invalid ways stay outside this block.

Top module: `plru_tracker`

## Requirements
- R1: After reset, the query port reports way 0 as the victim for every set.
- R2: One clock after an access to way w of a set, the victim of that set lies in the pair that does not hold w. The pairs are ways {0,1} and {2,3}, and a way number is its 2-bit binary value on `acc_way` and `qry_victim`.
- R3: The leaf bit of the accessed pair is set to point at the sibling of w. An access to w followed by an access to the other pair makes the sibling of w the victim.
- R4: An access leaves the leaf bit of the other pair unchanged. When the root later turns back to that pair, it yields the same way as before.
- R5: When an access and a query name the same set in the same cycle, the query returns the victim from before the update. The updated victim appears from the next cycle on.
- R6: When `acc_valid` is low, no set changes, whatever `acc_set` and `acc_way` carry.
- R7: An access changes only the set it names. The victims of all other sets are unchanged.
- R8: Starting from reset, the access order 3, 0, 2, 1 in one set leaves way 3 as its victim.
- R9: For any mix of accesses across sets, the victim of each set equals the decode of its three tree bits. The root bit selects pair {2,3} when 1, and the leaf bit of that pair selects the upper way when 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all tree bits |
| acc_valid | input | 1 | Access strobe; updates the named set on the next edge |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way that was accessed |
| qry_set | input | SET_W | Set index of the victim query |
| qry_victim | output | 2 | Victim way of the queried set, from its current bits |

## Verification
A wrong tree bit is not seen until a query reads its set, and only if the decode reaches that bit. A bad leaf bit stays hidden until the root turns to its pair, which can take several accesses. The bench therefore queries a set again one cycle after each update, and it also queries sets that were not accessed, so that a corrupted bit shows up within a cycle or two of being written. A long pseudo-random stream of accesses across the sets is compared against an arithmetic model. This exercises each root and leaf combination repeatedly.

// File: rtl/plru_pkg.sv
package plru_pkg;
   localparam int TREE_BITS = 3;
   localparam int WAY_W     = 2;
   localparam int ROOT_BIT  = 0;
   localparam int LO_BIT    = 1;
   localparam int HI_BIT    = 2;

   typedef logic [TREE_BITS-1:0] tree_t;
   typedef logic [WAY_W-1:0]     way_t;
endpackage

// File: rtl/plru_next_state.sv
module plru_next_state
   import plru_pkg::*;
(
   input  tree_t cur_bits,
   input  way_t  touch_way,
   output tree_t new_bits
);
   always_comb begin
      new_bits           = cur_bits;
      new_bits[ROOT_BIT] = ~touch_way[1];
      if (touch_way[1]) begin
         new_bits[HI_BIT] = ~touch_way[0];
      end else begin
         new_bits[LO_BIT] = ~touch_way[0];
      end
   end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
   import plru_pkg::*;
(
   input  tree_t tree_bits,
   output way_t  victim
);
   always_comb begin
      if (tree_bits[ROOT_BIT]) begin
         victim = {1'b1, tree_bits[HI_BIT]};
      end else begin
         victim = {1'b0, tree_bits[LO_BIT]};
      end
   end
endmodule

// File: rtl/plru_set_slot.sv
module plru_set_slot
   import plru_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  wr_en,
   input  tree_t wr_bits,
   output tree_t rd_bits
);
   tree_t bits_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         bits_q <= '0;
      end else if (wr_en) begin
         bits_q <= wr_bits;
      end
   end

   assign rd_bits = bits_q;
endmodule

// File: rtl/plru_tracker.sv
module plru_tracker
   import plru_pkg::*;
#(
   parameter int NUM_SETS = 64,
   parameter int NUM_WAYS = 4,
   localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [1:0]       acc_way,
   input  logic [SET_W-1:0] qry_set,
   output logic [1:0]       qry_victim
);
   localparam int SET_SPAN = 1 << SET_W;

   if (NUM_WAYS != 4) begin : g_bad_ways
      $error("plru_tracker: NUM_WAYS must be 4");
   end
   if (NUM_SETS < 2 || NUM_SETS != SET_SPAN) begin : g_bad_sets
      $error("plru_tracker: NUM_SETS must be a power of two, at least 2");
   end

   tree_t slot_bits [NUM_SETS];
   tree_t acc_bits;
   tree_t acc_next;
   tree_t qry_bits;

   assign acc_bits = slot_bits[acc_set];
   assign qry_bits = slot_bits[qry_set];

   plru_next_state u_next (
      .cur_bits  (acc_bits),
      .touch_way (acc_way),
      .new_bits  (acc_next)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_slot
      logic hit_s;
      assign hit_s = acc_valid && (acc_set == SET_W'(s));
      plru_set_slot u_slot (
         .clk     (clk),
         .rst     (rst),
         .wr_en   (hit_s),
         .wr_bits (acc_next),
         .rd_bits (slot_bits[s])
      );
   end

   plru_victim_sel u_vic (
      .tree_bits (qry_bits),
      .victim    (qry_victim)
   );
endmodule

// File: rtl/plru_tracker_chk.sv
module plru_tracker_chk #(
   parameter int SET_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             acc_valid,
   input logic [SET_W-1:0] acc_set,
   input logic [1:0]       acc_way,
   input logic [SET_W-1:0] qry_set,
   input logic [1:0]       qry_victim
);
   // R1: first cycle out of reset shows way 0
   a_r1_reset_victim: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) |-> qry_victim == 2'd0));

   // R2: after an access, the same set's victim is in the opposite pair
   a_r2_other_pair: assert property (@(posedge clk) disable iff (rst)
      ((!$past(rst) && $past(acc_valid) && qry_set == $past(acc_set))
         |-> qry_victim[1] != $past(acc_way[1])));

   // R6: idle cycle keeps the victim of a re-queried set
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      ((!$past(rst) && !$past(acc_valid) && qry_set == $past(qry_set))
         |-> qry_victim == $past(qry_victim)));

   // R7: an access to another set leaves this set's victim alone
   a_r7_other_set: assert property (@(posedge clk) disable iff (rst)
      ((!$past(rst) && $past(acc_valid) && qry_set == $past(qry_set)
         && qry_set != $past(acc_set))
         |-> qry_victim == $past(qry_victim)));
endmodule

bind plru_tracker plru_tracker_chk #(.SET_W(SET_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .acc_valid  (acc_valid),
   .acc_set    (acc_set),
   .acc_way    (acc_way),
   .qry_set    (qry_set),
   .qry_victim (qry_victim)
);

// File: tb/sim_plru_tracker.sv
`timescale 1ns/1ps
module sim_plru_tracker;
   localparam int NSETS = 8;
   localparam int SW    = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          acc_valid = 1'b0;
   logic [SW-1:0] acc_set = '0;
   logic [1:0]    acc_way = '0;
   logic [SW-1:0] qry_set = '0;
   logic [1:0]    qry_victim;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [2:0] model [NSETS];

   always #5 clk = ~clk;

   plru_tracker #(.NUM_SETS(NSETS)) u0 (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_way(acc_way), .qry_set(qry_set), .qry_victim(qry_victim)
   );

   function automatic logic [2:0] m_next(logic [2:0] b, logic [1:0] w);
      logic [2:0] r;
      r = b;
      r[0] = (w < 2) ? 1'b1 : 1'b0;
      if (w < 2) r[1] = (w == 0) ? 1'b1 : 1'b0;
      else       r[2] = (w == 2) ? 1'b1 : 1'b0;
      return r;
   endfunction

   function automatic logic [1:0] m_vic(logic [2:0] b);
      if (b[0]) return b[2] ? 2'd3 : 2'd2;
      return b[1] ? 2'd1 : 2'd0;
   endfunction

   task automatic chk(input string tag, input logic [1:0] exp_v);
      checks++;
      if (qry_victim !== exp_v) begin
         errors++;
         $display("FAIL %s set=%0d actual=%0d expected=%0d", tag, qry_set, qry_victim, exp_v);
      end
   endtask

   // called at a negedge: drive, sample pre-edge, step through the edge
   task automatic step(input logic v, input int s, input int w, input int q, input string tag);
      acc_valid = v;
      acc_set   = SW'(s);
      acc_way   = 2'(w);
      qry_set   = SW'(q);
      #1;
      chk(tag, m_vic(model[q]));
      @(posedge clk);
      if (v) model[s] = m_next(model[s], 2'(w));
      @(negedge clk);
   endtask

   task automatic peek(input int q, input logic [1:0] exp_v, input string tag);
      acc_valid = 1'b0;
      qry_set   = SW'(q);
      #1;
      chk(tag, exp_v);
      @(negedge clk);
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < NSETS; i++) model[i] = 3'b000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NSETS; i++) peek(i, 2'd0, "R1");

      // R8: order 3,0,2,1 in set 1
      step(1, 1, 3, 1, "R8");
      step(1, 1, 0, 1, "R8");
      step(1, 1, 2, 1, "R8");
      step(1, 1, 1, 1, "R8");
      peek(1, 2'd3, "R8");

      // R5: same-cycle access and query on set 2
      acc_valid = 1'b1; acc_set = 3'd2; acc_way = 2'd0; qry_set = 3'd2;
      #1;
      chk("R5", 2'd0);
      @(posedge clk);
      model[2] = m_next(model[2], 2'd0);
      @(negedge clk);
      peek(2, 2'd2, "R5");
      peek(2, 2'd2, "R2");

      // R3: way 2 then way 0 -> sibling of 2 (way 3)
      step(1, 3, 2, 3, "R3");
      step(1, 3, 0, 3, "R3");
      peek(3, 2'd3, "R3");
      // R4: touching pair {0,1} keeps pair {2,3} choice
      step(1, 3, 1, 3, "R4");
      peek(3, 2'd3, "R4");
      step(1, 3, 3, 3, "R4");
      peek(3, 2'd0, "R4");

      // R6: strobe low, other inputs active
      step(0, 3, 0, 3, "R6");
      peek(3, 2'd0, "R6");

      // R7: access set 0 leaves set 1 at way 3
      step(1, 0, 0, 1, "R7");
      peek(1, 2'd3, "R7");
      peek(0, 2'd2, "R2");

      // R9: pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), int'(lfsr[6:5]),
              (lfsr[7]) ? int'(lfsr[4:2]) : int'(lfsr[10:8]), "R9");
      end
      for (int i = 0; i < NSETS; i++) peek(i, m_vic(model[i]), "R9");

      finish_up();
   end
endmodule